// File: doc/BRIEF.md
# Trip-Threshold Programming Sequence Detector

This block listens to a mode 0 serial bus (clock idle low, data taken on the rising clock edge, most significant bit first) and looks for the two-frame command that authorizes a new supply trip threshold. The command is two frames. Each frame is exactly 24 bits. A chip-select deassertion of a minimum length separates the two frames. The whole command counts only while a program-enable input stays high. The last byte of the second frame selects one of two outcomes. One raises the threshold to the applied level. The other returns it to the native low level. The block reports the outcome as a single-cycle pulse on one of two outputs.

All bus pins and the enable are asynchronous to the system clock. The block brings them in through synchronizer chains and works on their edges in the system clock domain. After a pulse, a busy flag stays high for a parameterized recovery window. While busy is high, the bus is ignored. Any frame that is malformed, truncated or too long returns the detector to idle without a pulse.

Top module: `thr_prog_detect`

## Requirements
- R1: While and after a synchronous reset, `set_pulse`, `clear_pulse` and `busy` are 0 and the detector is idle.
- R2: An arming frame of 24 bits whose bytes are 03h, 00h, 01h, then a chip-select gap, then a 24-bit frame of 02h, 00h, 01h produces exactly one `set_pulse` of one cycle after `cs_n` rises at the end of the second frame. `si` is taken on each rising `sck` while `cs_n` is low, most significant bit first.
- R3: The same arming frame followed by a 24-bit frame of 02h, 00h, 03h produces exactly one `clear_pulse` of one cycle and no `set_pulse`.
- R4: A frame with fewer or more than 24 rising `sck` edges, in either position, produces no pulse and returns the detector to idle.
- R5: A frame whose bytes differ from the expected pattern, in either position, produces no pulse and returns the detector to idle. A correct command sent afterwards is accepted.
- R6: If `prog_en` is low when either frame closes, or at any cycle between the two frames, no pulse is produced. This includes `prog_en` falling together with the final `cs_n` rise.
- R7: If `cs_n` stays high for fewer than MIN_GAP system cycles between the two frames, no pulse is produced.
- R8: `busy` rises in the same cycle as a pulse and stays high for exactly RECOVERY system cycles.
- R9: A complete valid command whose frames close while `busy` is high produces no pulse.
- R10: `set_pulse` and `clear_pulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, asynchronous |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| si | input | 1 | Serial data in, asynchronous |
| prog_en | input | 1 | Program-enable level, asynchronous |
| set_pulse | output | 1 | One-cycle pulse: raise the threshold |
| clear_pulse | output | 1 | One-cycle pulse: return the threshold to native level |
| busy | output | 1 | High during the recovery window after a pulse |

## Verification
The close of the second frame and the loss of the enable can land in the same cycle. The bench provokes this by releasing `cs_n` and dropping `prog_en` at the same instant. Both pins pass through identical synchronizer depth, so they arrive together, and the bench requires that no pulse appears. A second collision is between the end of the recovery window and new bus traffic. The bench sends a complete valid command inside the busy window and counts that no second pulse appears. It then sends one after the window and requires it to be accepted.

// File: rtl/thr_prog_pkg.sv
package thr_prog_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_ARMED   = 2'd1,
    SEQ_RECOVER = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_SET   = 2'd1,
    KIND_CLEAR = 2'd2
  } cmd_kind_t;

endpackage

// File: rtl/tpd_sync.sv
module tpd_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/tpd_frame_rx.sv
module tpd_frame_rx #(
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck_s,
  input  logic                  cs_n_s,
  input  logic                  si_s,
  output logic                  frame_start,
  output logic                  frame_end,
  output logic                  frame_len_ok,
  output logic [FRAME_BITS-1:0] frame_word
);

  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic             sck_d, cs_d;
  logic [CNT_W-1:0] bit_cnt;
  logic             sck_rise, cs_fall, cs_rise;

  assign sck_rise = sck_s & ~sck_d;
  assign cs_fall  = ~cs_n_s & cs_d;
  assign cs_rise  = cs_n_s & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d        <= 1'b0;
      cs_d         <= 1'b1;
      bit_cnt      <= '0;
      frame_word   <= '0;
      frame_start  <= 1'b0;
      frame_end    <= 1'b0;
      frame_len_ok <= 1'b0;
    end else begin
      sck_d       <= sck_s;
      cs_d        <= cs_n_s;
      frame_start <= cs_fall;
      frame_end   <= cs_rise;
      if (cs_fall) begin
        bit_cnt    <= '0;
        frame_word <= '0;
      end else if (!cs_n_s && sck_rise) begin
        frame_word <= {frame_word[FRAME_BITS-2:0], si_s};
        if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
      end
      if (cs_rise) frame_len_ok <= (bit_cnt == CNT_FULL);
    end
  end

endmodule

// File: rtl/tpd_seq_fsm.sv
module tpd_seq_fsm
  import thr_prog_pkg::*;
#(
  parameter int                  FRAME_BITS = 24,
  parameter int                  MIN_GAP    = 16,
  parameter int                  RECOVERY   = 1000,
  parameter logic [FRAME_BITS-1:0] ARM_WORD   = 24'h030001,
  parameter logic [FRAME_BITS-1:0] SET_WORD   = 24'h020001,
  parameter logic [FRAME_BITS-1:0] CLEAR_WORD = 24'h020003
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en_s,
  input  logic                  cs_n_s,
  input  logic                  frame_start,
  input  logic                  frame_end,
  input  logic                  frame_len_ok,
  input  logic [FRAME_BITS-1:0] frame_word,
  output logic                  set_pulse,
  output logic                  clear_pulse,
  output logic                  busy
);

  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam int REC_W = $clog2(RECOVERY + 1);
  localparam logic [GAP_W-1:0] GAP_MIN  = GAP_W'(MIN_GAP);
  localparam logic [REC_W-1:0] REC_LOAD = REC_W'(RECOVERY - 1);

  seq_state_t       state;
  logic [GAP_W-1:0] gap_cnt;
  logic [REC_W-1:0] rec_cnt;
  cmd_kind_t        kind;

  always_comb begin
    kind = KIND_NONE;
    if (frame_len_ok && frame_word == SET_WORD)   kind = KIND_SET;
    if (frame_len_ok && frame_word == CLEAR_WORD) kind = KIND_CLEAR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SEQ_IDLE;
      gap_cnt     <= '0;
      rec_cnt     <= '0;
      set_pulse   <= 1'b0;
      clear_pulse <= 1'b0;
    end else begin
      set_pulse   <= 1'b0;
      clear_pulse <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          gap_cnt <= '0;
          if (frame_end && frame_len_ok && en_s && frame_word == ARM_WORD)
            state <= SEQ_ARMED;
        end
        SEQ_ARMED: begin
          if (cs_n_s && gap_cnt != GAP_MIN) gap_cnt <= gap_cnt + 1'b1;
          if (!en_s) begin
            state <= SEQ_IDLE;
          end else if (frame_start && gap_cnt < GAP_MIN) begin
            state <= SEQ_IDLE;
          end else if (frame_end) begin
            rec_cnt <= REC_LOAD;
            unique case (kind)
              KIND_SET: begin
                set_pulse <= 1'b1;
                state     <= SEQ_RECOVER;
              end
              KIND_CLEAR: begin
                clear_pulse <= 1'b1;
                state       <= SEQ_RECOVER;
              end
              default: state <= SEQ_IDLE;
            endcase
          end
        end
        SEQ_RECOVER: begin
          if (rec_cnt == '0) state <= SEQ_IDLE;
          else               rec_cnt <= rec_cnt - 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (state == SEQ_RECOVER);

endmodule

// File: rtl/thr_prog_detect.sv
module thr_prog_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 24,
  parameter int MIN_GAP     = 16,
  parameter int RECOVERY    = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic prog_en,
  output logic set_pulse,
  output logic clear_pulse,
  output logic busy
);

  logic [3:0]            pins_s;
  logic                  frame_start, frame_end, frame_len_ok;
  logic [FRAME_BITS-1:0] frame_word;

  // bit order: {prog_en, si, cs_n, sck}; chip select rests high
  tpd_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0010)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async({prog_en, si, cs_n, sck}),
    .q_sync (pins_s)
  );

  tpd_frame_rx #(
    .FRAME_BITS(FRAME_BITS)
  ) u_rx (
    .clk         (clk),
    .rst         (rst),
    .sck_s       (pins_s[0]),
    .cs_n_s      (pins_s[1]),
    .si_s        (pins_s[2]),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .frame_len_ok(frame_len_ok),
    .frame_word  (frame_word)
  );

  tpd_seq_fsm #(
    .FRAME_BITS(FRAME_BITS),
    .MIN_GAP   (MIN_GAP),
    .RECOVERY  (RECOVERY)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .en_s        (pins_s[3]),
    .cs_n_s      (pins_s[1]),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .frame_len_ok(frame_len_ok),
    .frame_word  (frame_word),
    .set_pulse   (set_pulse),
    .clear_pulse (clear_pulse),
    .busy        (busy)
  );

endmodule

// File: rtl/thr_prog_detect_chk.sv
module thr_prog_detect_chk #(
  parameter int RECOVERY = 1000
) (
  input logic clk,
  input logic rst,
  input logic set_pulse,
  input logic clear_pulse,
  input logic busy
);

  localparam int RUN_W = $clog2(RECOVERY + 2);
  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!set_pulse && !clear_pulse && !busy));

  assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(set_pulse && clear_pulse));

  assert_set_single_R2: assert property (@(posedge clk) disable iff (rst)
    set_pulse |=> !set_pulse);

  assert_clear_single_R3: assert property (@(posedge clk) disable iff (rst)
    clear_pulse |=> !clear_pulse);

  assert_pulse_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (set_pulse || clear_pulse) |-> busy);

  assert_busy_length_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run == RUN_W'(RECOVERY)));

  assert_no_pulse_in_recovery_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (!set_pulse && !clear_pulse));

endmodule

bind thr_prog_detect thr_prog_detect_chk #(
  .RECOVERY(RECOVERY)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .set_pulse  (set_pulse),
  .clear_pulse(clear_pulse),
  .busy       (busy)
);

// File: tb/test_thr_prog_detect.sv
`timescale 1ns/1ps
module test_thr_prog_detect;

  localparam int RECOVERY = 1000;
  localparam int MIN_GAP  = 16;
  localparam logic [23:0] ARM = 24'h030001;
  localparam logic [23:0] SET = 24'h020001;
  localparam logic [23:0] CLR = 24'h020003;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, prog_en = 1'b0;
  logic set_pulse, clear_pulse, busy;

  int total = 0, bad = 0;
  int set_cnt = 0, clr_cnt = 0, both_cnt = 0;
  int run = 0, last_run = 0;

  always #2 clk = ~clk;

  thr_prog_detect #(.MIN_GAP(MIN_GAP), .RECOVERY(RECOVERY)) i_thr_prog_detect (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .prog_en(prog_en),
    .set_pulse(set_pulse), .clear_pulse(clear_pulse), .busy(busy)
  );

  always @(posedge clk) begin
    if (set_pulse) set_cnt <= set_cnt + 1;
    if (clear_pulse) clr_cnt <= clr_cnt + 1;
    if (set_pulse && clear_pulse) both_cnt <= both_cnt + 1;
    if (busy) run <= run + 1;
    else begin
      if (run != 0) last_run <= run;
      run <= 0;
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nbits bits: the word MSB first, then zero bits past 24.
  task automatic send_frame(input logic [23:0] w, input int nbits, input bit drop_en);
    @(negedge clk);
    cs_n = 1'b0;
    idle(4);
    for (int i = 0; i < nbits; i++) begin
      si = (i < 24) ? w[23-i] : 1'b0;
      idle(4);
      sck = 1'b1;
      idle(4);
      sck = 1'b0;
    end
    idle(4);
    cs_n = 1'b1;
    if (drop_en) prog_en = 1'b0;
  endtask

  task automatic send_seq(input logic [23:0] a, input int na,
                          input logic [23:0] b, input int nb, input int gap);
    send_frame(a, na, 1'b0);
    idle(gap);
    send_frame(b, nb, 1'b0);
    idle(30);
  endtask

  task automatic expect_pulses(input string req, input int s0, input int c0,
                               input int ds, input int dc);
    check_eq({req, " set pulses"}, set_cnt - s0, ds);
    check_eq({req, " clear pulses"}, clr_cnt - c0, dc);
  endtask

  task automatic t_reset_r1;
    idle(1);
    check_eq("R1 set_pulse", int'(set_pulse), 0);
    check_eq("R1 clear_pulse", int'(clear_pulse), 0);
    check_eq("R1 busy", int'(busy), 0);
  endtask

  task automatic t_set_r2;
    int s0 = set_cnt, c0 = clr_cnt;
    prog_en = 1'b1;
    idle(10);
    send_seq(ARM, 24, SET, 24, 40);
    expect_pulses("R2", s0, c0, 1, 0);
    check_eq("R8 busy during recovery", int'(busy), 1);
    idle(RECOVERY + 20);
    check_eq("R8 busy length", last_run, RECOVERY);
    check_eq("R8 busy cleared", int'(busy), 0);
  endtask

  task automatic t_clear_r3;
    int s0 = set_cnt, c0 = clr_cnt;
    send_seq(ARM, 24, CLR, 24, 40);
    expect_pulses("R3", s0, c0, 0, 1);
    idle(RECOVERY + 20);
    check_eq("R8 busy length after clear", last_run, RECOVERY);
  endtask

  task automatic t_length_r4;
    int s0 = set_cnt, c0 = clr_cnt;
    send_seq(ARM, 23, SET, 24, 40);
    send_seq(ARM, 24, SET, 25, 40);
    send_seq(ARM, 25, CLR, 24, 40);
    send_seq(ARM, 24, CLR, 23, 40);
    expect_pulses("R4", s0, c0, 0, 0);
  endtask

  task automatic t_bytes_r5;
    int s0 = set_cnt, c0 = clr_cnt;
    send_seq(24'h030002, 24, SET, 24, 40);
    send_seq(ARM, 24, 24'h020101, 24, 40);
    send_seq(ARM, 24, ARM, 24, 40);
    expect_pulses("R5 wrong bytes", s0, c0, 0, 0);
    send_seq(ARM, 24, SET, 24, 40);
    expect_pulses("R5 accepted after reject", s0, c0, 1, 0);
    idle(RECOVERY + 20);
  endtask

  task automatic t_enable_r6;
    int s0 = set_cnt, c0 = clr_cnt;
    prog_en = 1'b0;
    idle(10);
    send_seq(ARM, 24, SET, 24, 40);
    expect_pulses("R6 enable low", s0, c0, 0, 0);
    prog_en = 1'b1;
    idle(10);
    send_frame(ARM, 24, 1'b0);
    idle(10);
    prog_en = 1'b0;
    idle(5);
    prog_en = 1'b1;
    idle(25);
    send_frame(CLR, 24, 1'b0);
    idle(30);
    expect_pulses("R6 enable glitch between", s0, c0, 0, 0);
    send_frame(ARM, 24, 1'b0);
    idle(40);
    send_frame(SET, 24, 1'b1);
    idle(30);
    expect_pulses("R6 enable drop at close", s0, c0, 0, 0);
    prog_en = 1'b1;
    idle(10);
  endtask

  task automatic t_gap_r7;
    int s0 = set_cnt, c0 = clr_cnt;
    send_seq(ARM, 24, SET, 24, 4);
    expect_pulses("R7 short gap", s0, c0, 0, 0);
  endtask

  task automatic t_busy_r9;
    int s0 = set_cnt, c0 = clr_cnt;
    send_seq(ARM, 24, SET, 24, 40);
    send_seq(ARM, 24, CLR, 24, 40);
    check_eq("R9 still busy", int'(busy), 1);
    expect_pulses("R9 ignored while busy", s0, c0, 1, 0);
    idle(RECOVERY);
    send_seq(ARM, 24, CLR, 24, 40);
    expect_pulses("R9 accepted after recovery", s0, c0, 1, 1);
    idle(RECOVERY + 20);
    check_eq("R10 simultaneous pulses", both_cnt, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(5);
    t_reset_r1();
    rst = 1'b0;
    idle(5);
    t_reset_r1();
    t_set_r2();
    t_clear_r3();
    t_length_r4();
    t_bytes_r5();
    t_enable_r6();
    t_gap_r7();
    t_busy_r9();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule